// File: doc/BRIEF.md
# External DMA Request Handshake Channel

This block is one channel of the glue between an external I/O device and a DMA engine that runs single-address transfers. The device raises a request pin. The channel passes that pin through a synchroniser and detects it either by level or by rising edge. It then offers a transfer request to the engine over a valid/ready pair. Once the engine accepts, the channel drives an acknowledge pin to the device. That pin stays active until the bus access that the engine runs has completed.

A transfer-done pin works in one of two directions. As an output, it marks the end of each transfer with a single-cycle strobe inside the acknowledge window. As an input, it lets the device cut a transfer short: the channel then sends a one-cycle terminate pulse to the engine and returns to idle. Configuration inputs set the request polarity, the acknowledge polarity (which also applies to the done pin), the detection mode and the direction of the done pin. The engine reports its bus phases on three plain status inputs: chip-enable active, ready active, and last access.

The request side follows valid/ready rules. Once `xfer_req_valid` rises, it stays high until a cycle in which `xfer_req_ready` is also high. That cycle is the handshake. The engine may hold `xfer_req_ready` low for any number of cycles, and no request is lost or repeated while it does.

Top module: `dma_xreq_chan`

## Requirements
- R1: While `rst_n` is low, and after it is released until a request arrives, `ack_pin` is at its inactive level (the complement of `cfg_ack_pol`). While `rst_n` is low, `done_o` is also inactive and `done_oe`, `xfer_req_valid` and `term_pulse` are 0.
- R2: `cfg_req_pol` set to 1 makes `req_pin` active high; set to 0 makes it active low. The pin passes through two synchroniser flops. A request seen while idle raises `xfer_req_valid` at the third rising clock edge after the pin changes.
- R3: Once `xfer_req_valid` is high, it stays high until a cycle in which `xfer_req_ready` is high, and it falls after that handshake.
- R4: Starting the clock edge after the handshake, `ack_pin` sits at its active level, which equals `cfg_ack_pol` (0 means active low).
- R5: `ack_pin` turns active only on the edge that follows a handshake. The acknowledge is therefore already active in, or before, the first cycle of chip-enable for that transfer.
- R6: The acknowledge is never released while `bus_ce` or `bus_rdy` is active. The only exception is a terminate under R10. Without a terminate, the release comes only after `bus_ce` and `bus_rdy` are both inactive following a cycle that showed `bus_ce` together with `bus_last`.
- R7: With `cfg_edge_mode` set to 1, a transfer starts only on an inactive-to-active change of the synchronised request while idle. A change that occurs while a request is pending or acknowledged is dropped. A request still held active after the acknowledge is released starts nothing.
- R8: With `cfg_edge_mode` set to 0, a request still active once the channel is idle again starts the next transfer.
- R9: With `cfg_done_out` set to 1, `done_oe` is 1. `done_o` goes active for exactly one cycle, on the edge after the cycle in which the final bus phase ends. During that cycle the acknowledge is still active, and the acknowledge is released on the following edge.
- R10: With `cfg_done_out` set to 0, `done_i` is read with the acknowledge polarity (active when it equals `cfg_ack_pol`). `done_i` active during the acknowledge window produces a one-cycle `term_pulse`. The acknowledge is released on that same edge.
- R11: In input mode, `done_i` active while the acknowledge is inactive is ignored: no `term_pulse` and no change of state.
- R12: In input mode, a transfer that ends without a done input releases the acknowledge on the edge after the final bus phase ends. `term_pulse` stays 0 and `done_o` stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req_pol | input | 1 | Request pin polarity, 1 = active high |
| cfg_ack_pol | input | 1 | Acknowledge and done pin polarity, 1 = active high |
| cfg_edge_mode | input | 1 | 1 = edge-detected request, 0 = level |
| cfg_done_out | input | 1 | 1 = done pin driven out, 0 = done pin sampled in |
| req_pin | input | 1 | Request from the external device |
| ack_pin | output | 1 | Acknowledge to the external device |
| done_o | output | 1 | Done strobe, driven value |
| done_oe | output | 1 | Done pin output enable |
| done_i | input | 1 | Done strobe, sampled value |
| bus_ce | input | 1 | Engine's chip-enable is active this cycle |
| bus_rdy | input | 1 | Ready/ACK phase is active this cycle |
| bus_last | input | 1 | Current access is the last of the transfer |
| xfer_req_valid | output | 1 | Transfer request to the engine |
| xfer_req_ready | input | 1 | Engine accepts the transfer request |
| term_pulse | output | 1 | One-cycle terminate toward the engine |

## Verification
The assertions check the cycle-local rules on every cycle:
- the request stays valid under back-pressure;
- the acknowledge rises only after a handshake;
- the acknowledge is held while chip-enable or ready is active;
- the done strobe lasts one cycle and falls inside the acknowledge window;
- the terminate pulse lasts one cycle and coincides with the acknowledge release.

Only the bench scenarios can show the rules that depend on history. These are the synchroniser latency, edge-mode masking of a request that toggles or stays held across the acknowledge, back-to-back restarts in level mode, and a done input being ignored outside the window. The scenarios run under both polarity settings.

// File: rtl/dma_xreq_pkg.sv
`timescale 1ns/1ps
package dma_xreq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2,
    ST_DONE = 2'd3
  } xreq_state_e;
endpackage

// File: rtl/dma_xreq_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser; resets to the inactive (0) level.
module dma_xreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/dma_xreq_detect.sv
`timescale 1ns/1ps
// Level or rising-edge detection of the normalised, synchronised request.
module dma_xreq_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic req_act,
  input  logic edge_mode,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= req_act;
  end

  assign hit = edge_mode ? (req_act & ~prev_q) : req_act;
endmodule

// File: rtl/dma_xreq_fsm.sv
`timescale 1ns/1ps
// Channel sequencer: request offer, acknowledge window, done/terminate.
module dma_xreq_fsm
  import dma_xreq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic done_is_out,
  input  logic done_in_act,
  input  logic bus_ce,
  input  logic bus_rdy,
  input  logic bus_last,
  input  logic xfer_req_ready,
  output logic xfer_req_valid,
  output logic ack_act,
  output logic done_act,
  output logic term_pulse
);
  xreq_state_e st_q, st_nxt;
  logic last_seen_q, last_seen_nxt;
  logic term_nxt;
  logic bus_quiet;

  assign bus_quiet = ~bus_ce & ~bus_rdy;

  always_comb begin
    st_nxt   = st_q;
    term_nxt = 1'b0;
    unique case (st_q)
      ST_IDLE: if (hit) st_nxt = ST_REQ;
      ST_REQ:  if (xfer_req_ready) st_nxt = ST_ACK;
      ST_ACK: begin
        if (!done_is_out && done_in_act) begin
          st_nxt   = ST_IDLE;
          term_nxt = 1'b1;
        end else if (last_seen_q && bus_quiet) begin
          st_nxt = done_is_out ? ST_DONE : ST_IDLE;
        end
      end
      ST_DONE: st_nxt = ST_IDLE;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    if (st_q == ST_ACK && st_nxt == ST_ACK)
      last_seen_nxt = last_seen_q | (bus_ce & bus_last);
    else
      last_seen_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q           <= ST_IDLE;
      last_seen_q    <= 1'b0;
      xfer_req_valid <= 1'b0;
      ack_act        <= 1'b0;
      done_act       <= 1'b0;
      term_pulse     <= 1'b0;
    end else begin
      st_q           <= st_nxt;
      last_seen_q    <= last_seen_nxt;
      xfer_req_valid <= (st_nxt == ST_REQ);
      ack_act        <= (st_nxt == ST_ACK) || (st_nxt == ST_DONE);
      done_act       <= (st_nxt == ST_DONE);
      term_pulse     <= term_nxt;
    end
  end
endmodule

// File: rtl/dma_xreq_chan.sv
`timescale 1ns/1ps
module dma_xreq_chan #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_req_pol,
  input  logic cfg_ack_pol,
  input  logic cfg_edge_mode,
  input  logic cfg_done_out,
  input  logic req_pin,
  output logic ack_pin,
  output logic done_o,
  output logic done_oe,
  input  logic done_i,
  input  logic bus_ce,
  input  logic bus_rdy,
  input  logic bus_last,
  output logic xfer_req_valid,
  input  logic xfer_req_ready,
  output logic term_pulse
);
  logic req_norm, req_sync, hit;
  logic ack_act, done_act, done_in_act;

  // Normalise before synchronising so reset means "no request".
  assign req_norm    = req_pin ~^ cfg_req_pol;
  assign done_in_act = done_i  ~^ cfg_ack_pol;

  dma_xreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(req_norm), .q(req_sync)
  );

  dma_xreq_detect u_det (
    .clk(clk), .rst_n(rst_n), .req_act(req_sync),
    .edge_mode(cfg_edge_mode), .hit(hit)
  );

  dma_xreq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .done_is_out(cfg_done_out), .done_in_act(done_in_act),
    .bus_ce(bus_ce), .bus_rdy(bus_rdy), .bus_last(bus_last),
    .xfer_req_ready(xfer_req_ready), .xfer_req_valid(xfer_req_valid),
    .ack_act(ack_act), .done_act(done_act), .term_pulse(term_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_oe <= 1'b0;
    else        done_oe <= cfg_done_out;
  end

  // Pin levels: registered activity flag mapped through a static polarity bit.
  assign ack_pin = ack_act  ~^ cfg_ack_pol;
  assign done_o  = done_act ~^ cfg_ack_pol;
endmodule

// File: rtl/dma_xreq_chk.sv
`timescale 1ns/1ps
module dma_xreq_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_ack_pol,
  input logic ack_pin,
  input logic done_o,
  input logic done_oe,
  input logic xfer_req_valid,
  input logic xfer_req_ready,
  input logic bus_ce,
  input logic bus_rdy,
  input logic term_pulse
);
  logic ack_on, done_on;
  assign ack_on  = (ack_pin == cfg_ack_pol);
  assign done_on = (done_o  == cfg_ack_pol);

  a_r3_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_valid && !xfer_req_ready |=> xfer_req_valid);

  a_r5_ack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_on) |-> $past(xfer_req_valid && xfer_req_ready));

  a_r6_ack_held_on_bus: assert property (@(posedge clk) disable iff (!rst_n)
    ack_on && (bus_ce || bus_rdy) |=> ack_on || term_pulse);

  a_r9_done_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    done_on |-> ack_on && done_oe);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_on |=> !done_on);

  a_r10_term_single: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |=> !term_pulse);

  a_r10_term_releases: assert property (@(posedge clk) disable iff (!rst_n)
    term_pulse |-> !ack_on && !done_oe);
endmodule

bind dma_xreq_chan dma_xreq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ack_pol(cfg_ack_pol), .ack_pin(ack_pin),
  .done_o(done_o), .done_oe(done_oe), .xfer_req_valid(xfer_req_valid),
  .xfer_req_ready(xfer_req_ready), .bus_ce(bus_ce), .bus_rdy(bus_rdy),
  .term_pulse(term_pulse)
);

// File: tb/sim_dma_xreq_chan.sv
`timescale 1ns/1ps
module sim_dma_xreq_chan;
  localparam int BEATS = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_req_pol = 1'b0, cfg_ack_pol = 1'b0, cfg_edge_mode = 1'b0, cfg_done_out = 1'b1;
  logic req_pin = 1'b1, done_i = 1'b1;
  logic bus_ce = 1'b0, bus_rdy = 1'b0, bus_last = 1'b0, xfer_req_ready = 1'b0;
  logic ack_pin, done_o, done_oe, xfer_req_valid, term_pulse;

  int vectors = 0, errors = 0;
  int ack_rises = 0, done_pulses = 0, terms = 0;
  int eng_stall = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dma_xreq_chan u0 (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, evaluated at every rising edge.
  bit ms1, ms2, mprev, mlast, mvalid, mack, mdone, mterm, moe;
  int mst;
  always @(posedge clk) begin
    if (!rst_n) begin
      ms1 = 0; ms2 = 0; mprev = 0; mlast = 0; mst = 0;
      mvalid = 0; mack = 0; mdone = 0; mterm = 0; moe = 0;
    end else begin
      bit ract, hit, din;
      int nst;
      ract = ms2;
      hit = cfg_edge_mode ? (ract && !mprev) : ract;
      mprev = ract;
      ms2 = ms1;
      ms1 = (req_pin == cfg_req_pol);
      din = (done_i == cfg_ack_pol);
      nst = mst;
      mterm = 0;
      if (mst == 0 && hit) nst = 1;
      else if (mst == 1 && xfer_req_ready) nst = 2;
      else if (mst == 2) begin
        if (!cfg_done_out && din) begin nst = 0; mterm = 1; end
        else if (mlast && !bus_ce && !bus_rdy) nst = cfg_done_out ? 3 : 0;
      end else if (mst == 3) nst = 0;
      mlast = (mst == 2 && nst == 2) ? (mlast || (bus_ce && bus_last)) : 0;
      mst = nst;
      mvalid = (nst == 1);
      mack = (nst == 2 || nst == 3);
      mdone = (nst == 3);
      moe = cfg_done_out;
    end
  end

  // Per-cycle comparison and event counting, away from the active edge.
  bit ack_was = 0;
  always @(negedge clk) begin
    bit ackon, ok;
    ackon = (ack_pin === cfg_ack_pol);
    ok = 1;
    if (xfer_req_valid !== mvalid) begin ok = 0;
      $display("FAIL R2 R3 xfer_req_valid actual=%0b expected=%0b", xfer_req_valid, mvalid); end
    if (ack_pin !== (mack ? cfg_ack_pol : !cfg_ack_pol)) begin ok = 0;
      $display("FAIL R4 R5 R6 ack_pin actual=%0b expected=%0b", ack_pin, mack ? cfg_ack_pol : !cfg_ack_pol); end
    if (done_o !== (mdone ? cfg_ack_pol : !cfg_ack_pol)) begin ok = 0;
      $display("FAIL R9 done_o actual=%0b expected=%0b", done_o, mdone ? cfg_ack_pol : !cfg_ack_pol); end
    if (done_oe !== moe) begin ok = 0;
      $display("FAIL R9 done_oe actual=%0b expected=%0b", done_oe, moe); end
    if (term_pulse !== mterm) begin ok = 0;
      $display("FAIL R10 term_pulse actual=%0b expected=%0b", term_pulse, mterm); end
    vectors++;
    if (!ok) errors++;
    if (ackon && !ack_was) ack_rises++;
    ack_was = ackon;
    if (done_oe && done_o === cfg_ack_pol) done_pulses++;
    if (term_pulse === 1'b1) terms++;
  end

  // Engine emulation: grants after eng_stall cycles, then runs BEATS beats.
  int cnt = 0, wait_c = 0;
  always @(negedge clk) begin
    if (!rst_n || ack_pin !== cfg_ack_pol) begin
      cnt = 0; bus_ce = 0; bus_rdy = 0; bus_last = 0;
      if (xfer_req_valid === 1'b1 && !xfer_req_ready) begin
        if (wait_c >= eng_stall) begin xfer_req_ready = 1; wait_c = 0; end
        else wait_c++;
      end else begin
        xfer_req_ready = 0; wait_c = 0;
      end
    end else begin
      xfer_req_ready = 0;
      cnt++;
      bus_ce = (cnt <= 2 * BEATS);
      bus_rdy = bus_ce && (cnt % 2 == 0);
      bus_last = bus_ce && (cnt >= 2 * BEATS - 1);
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rises(input int n);
    while (ack_rises < n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    int base;
    cycles(3);
    // R1: reset state
    check(ack_pin == 1'b1, "R1 ack_pin inactive", ack_pin, 1);
    check(done_oe == 1'b0 && xfer_req_valid == 1'b0 && term_pulse == 1'b0,
          "R1 outputs idle", {done_oe, xfer_req_valid, term_pulse}, 0);
    rst_n = 1'b1;
    cycles(4);
    check(ack_rises == 0, "R1 no ack after reset", ack_rises, 0);

    // R2 R4 R9: active-low level request, done driven out
    req_pin = 1'b0;
    wait_rises(1);
    req_pin = 1'b1;
    cycles(12);
    check(ack_rises == 1, "R2 one transfer", ack_rises, 1);
    check(done_pulses == 1, "R9 one done strobe", done_pulses, 1);

    // R8: held level request restarts after release
    req_pin = 1'b0;
    wait_rises(3);
    req_pin = 1'b1;
    cycles(15);
    check(ack_rises == 3, "R8 back-to-back restarts", ack_rises, 3);
    check(done_pulses == 3, "R9 strobe per transfer", done_pulses, 3);

    // R3: back-pressure on the request
    eng_stall = 5;
    req_pin = 1'b0;
    wait_rises(4);
    req_pin = 1'b1;
    cycles(12);
    eng_stall = 0;
    check(ack_rises == 4, "R3 stalled request granted once", ack_rises, 4);

    // R7: edge mode, active-high request and acknowledge
    cfg_req_pol = 1'b1; cfg_ack_pol = 1'b1; cfg_edge_mode = 1'b1;
    req_pin = 1'b0; done_i = 1'b0;
    cycles(6);
    base = ack_rises;
    req_pin = 1'b1;
    wait_rises(base + 1);
    cycles(1); req_pin = 1'b0;
    cycles(1); req_pin = 1'b1;
    cycles(20);
    check(ack_rises == base + 1, "R7 edge during ack and held request ignored", ack_rises, base + 1);
    req_pin = 1'b0;
    cycles(5);
    req_pin = 1'b1;
    cycles(15);
    check(ack_rises == base + 2, "R7 fresh edge accepted", ack_rises, base + 2);
    req_pin = 1'b0;
    cycles(5);

    // R11: done input outside window
    cfg_done_out = 1'b0;
    cycles(3);
    done_i = 1'b1; cycles(1); done_i = 1'b0;
    cycles(5);
    check(terms == 0, "R11 stray done ignored", terms, 0);
    check(ack_rises == base + 2, "R11 no transfer from done", ack_rises, base + 2);

    // R10: done input terminates
    req_pin = 1'b1;
    wait_rises(base + 3);
    req_pin = 1'b0;
    cycles(1);
    done_i = 1'b1; cycles(1); done_i = 1'b0;
    cycles(8);
    check(terms == 1, "R10 terminate pulse", terms, 1);
    check(ack_pin == 1'b0, "R10 ack released", ack_pin, 0);

    // R12: input mode, normal completion
    base = done_pulses;
    req_pin = 1'b1;
    wait_rises(ack_rises + 1);
    req_pin = 1'b0;
    cycles(15);
    check(ack_pin == 1'b0, "R12 ack released", ack_pin, 0);
    check(terms == 1, "R12 no terminate", terms, 1);
    check(done_pulses == base && done_oe == 1'b0, "R12 done not driven", done_pulses, base);

    finished = 1;
    summary();
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      vectors++; errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule